// File: doc/BRIEF.md
# Write-Through Invalidating Line Coherence Controller

This block keeps one processor's private cache consistent with the other caches on a shared bus. Every store goes out to memory through the bus. Any store by another agent that hits a locally held line removes that line. The controller holds a small direct-mapped array of one-word lines. Each line carries a valid bit, a tag and a data word, so a line can only be present or absent.

The processor side uses a ready/valid handshake. A load that finds its line completes in the same cycle. A load that misses, and every store, raises a request on the bus port and waits. The bus port is a simple request/grant interface, and a completion strobe ends each transfer. Each transaction carries the controller's own agent number.

A second, independent tag lookup watches the bus at all times. When another agent writes an address that is held here, that line is dropped. The controller's own transactions are told apart by the agent number, so they never invalidate a local line.

Top module: `wti_snoop_ctrl`

## Requirements
- R1: After synchronous reset, all lines are invalid, `bus_req` and `cpu_ready` are low, and the first load to any address misses.
- R2: A load whose index holds a valid line with a matching tag raises `cpu_ready` in the same cycle as `cpu_valid`, returns the stored word, and leaves `bus_req` low. The index is the low `IDX_W` bits of the word address; the tag is the remaining upper bits.
- R3: A load that misses raises `bus_req` in the cycle after it is presented, with `bus_we` = 0 and `bus_addr` = `cpu_addr`. `bus_req` and the address stay unchanged until `bus_gnt` is seen.
- R4: After the grant for a load miss, `cpu_ready` rises in the cycle `bus_done` is high, with `cpu_rdata` = `bus_rdata`. The line is then valid with that word, so the next load to the address hits.
- R5: Every store, hit or miss, goes to the bus with `bus_we` = 1, the store address and the store data. The store completes only in the cycle `bus_done` is high.
- R6: A store that hits updates the local word in the cycle its request is granted. A store that misses leaves its line unchanged, so no allocation happens.
- R7: A bus write (`snp_valid` = 1, `snp_write` = 1) from an agent whose `snp_id` differs from `AGENT_ID` invalidates the line if the address matches a valid line. The next load to that address then misses.
- R8: Snooped transactions carrying `snp_id` = `AGENT_ID`, and snooped bus reads from any agent, leave every line unchanged.
- R9: A snoop in the same cycle as a load hit does not stall the load. If both address the same line, the load returns the old word and the line is invalid afterwards.
- R10: Only one bus transaction is outstanding. `bus_req` drops in the cycle after a grant, and no new request starts until the processor handshake completes.
- R11: A foreign bus write whose address has the same index but a different tag than the held line leaves that line valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present; held until `cpu_ready` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address of the request |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant, accepted while `bus_req` is high |
| bus_we | output | 1 | Transaction is a write |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Transaction write data |
| bus_src | output | IDW | This controller's agent number |
| bus_rdata | input | DW | Read data returned with `bus_done` |
| bus_done | input | 1 | Granted transaction finished |
| snp_valid | input | 1 | Another bus transaction is visible |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_addr | input | AW | Snooped address |
| snp_id | input | IDW | Agent number of the snooped transaction |

## Verification
The hardest case to reach from the ports is a snoop that strikes the very line a load is hitting, in the same cycle. The old word must still be returned without a stall, and the line must be gone one cycle later. The bench drives the snoop fields and a load to a resident address on the same falling edge, and releases the snoop after that single cycle. A follow-up load then shows the miss. Long grant delays keep a request pending over many cycles while the reference model checks it on every clock, and different-tag snoops to the same index exercise the tag compare on the snoop port.

// File: rtl/wti_pkg.sv
package wti_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ARB  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_t;

    // True when a snooped transaction is a write issued by some other agent.
    function automatic logic foreign_write(input logic vld, input logic we,
                                           input int unsigned src, input int unsigned own);
        return vld && we && (src != own);
    endfunction

endpackage

// File: rtl/wti_line_store.sv
module wti_line_store #(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    // processor lookup port
    input  logic [IDX_W-1:0] p_idx,
    input  logic [TAG_W-1:0] p_tag,
    output logic             p_hit,
    output logic [DW-1:0]    p_data,
    // snoop lookup port
    input  logic [IDX_W-1:0] s_idx,
    input  logic [TAG_W-1:0] s_tag,
    input  logic             s_kill_req,
    output logic             s_hit,
    // fill after a load miss
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [DW-1:0]    fill_data,
    // word update on a granted store hit
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [DW-1:0]    upd_data
);
    localparam int NLINES = 1 << IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [DW-1:0]    word;
    } line_t;

    line_t ent [NLINES];

    // Two independent read ports: processor and snoop never contend.
    assign p_hit  = ent[p_idx].valid && (ent[p_idx].tag == p_tag);
    assign p_data = ent[p_idx].word;
    assign s_hit  = ent[s_idx].valid && (ent[s_idx].tag == s_tag);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        line_t q;
        logic  fill_here, upd_here, kill_here;

        assign fill_here = fill_en && (fill_idx == IDX_W'(g));
        assign upd_here  = upd_en  && (upd_idx  == IDX_W'(g));
        // Invalidation is judged against the line as it stands after any local write.
        assign kill_here = s_kill_req && (s_idx == IDX_W'(g)) &&
                           (fill_here ? (fill_tag == s_tag) : s_hit);

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                q.valid <= (fill_here || q.valid) && !kill_here;
                if (fill_here) begin
                    q.tag  <= fill_tag;
                    q.word <= fill_data;
                end else if (upd_here) begin
                    q.word <= upd_data;
                end
            end
        end

        assign ent[g] = q;
    end

    // R6: a fill and a store update are never requested together
    p_single_write_r6: assert property (@(posedge clk) disable iff (rst)
        !(fill_en && upd_en))
        else $error("fill and update requested in one cycle");

endmodule

// File: rtl/wti_req_seq.sv
module wti_req_seq
    import wti_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_valid,
    input  logic cpu_write,
    input  logic p_hit,
    input  logic bus_gnt,
    input  logic bus_done,
    output logic cpu_ready,
    output logic bus_req,
    output logic bus_act,
    output logic sel_bus,
    output logic fill_en,
    output logic upd_en
);
    seq_state_t st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            SEQ_IDLE: if (cpu_valid && (cpu_write || !p_hit)) st_nx = SEQ_ARB;
            SEQ_ARB:  if (bus_gnt)  st_nx = SEQ_WAIT;
            SEQ_WAIT: if (bus_done) st_nx = SEQ_IDLE;
            default:  st_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SEQ_IDLE;
        else     st <= st_nx;
    end

    assign bus_req   = (st == SEQ_ARB);
    assign bus_act   = (st != SEQ_IDLE);
    assign sel_bus   = (st == SEQ_WAIT);
    assign cpu_ready = ((st == SEQ_IDLE) && cpu_valid && !cpu_write && p_hit) ||
                       ((st == SEQ_WAIT) && bus_done);
    assign upd_en    = (st == SEQ_ARB) && bus_gnt && cpu_write && p_hit;
    assign fill_en   = (st == SEQ_WAIT) && bus_done && !cpu_write;

endmodule

// File: rtl/wti_snoop_filter.sv
module wti_snoop_filter
    import wti_pkg::*;
#(
    parameter int IDW      = 2,
    parameter int AGENT_ID = 1
) (
    input  logic           snp_valid,
    input  logic           snp_write,
    input  logic [IDW-1:0] snp_id,
    output logic           kill_req
);
    assign kill_req = foreign_write(snp_valid, snp_write, int'(snp_id), AGENT_ID);
endmodule

// File: rtl/wti_snoop_ctrl.sv
module wti_snoop_ctrl #(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int IDX_W    = 2,
    parameter int IDW      = 2,
    parameter int AGENT_ID = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cpu_valid,
    input  logic           cpu_write,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_wdata,
    output logic           cpu_ready,
    output logic [DW-1:0]  cpu_rdata,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    output logic [IDW-1:0] bus_src,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_done,
    input  logic           snp_valid,
    input  logic           snp_write,
    input  logic [AW-1:0]  snp_addr,
    input  logic [IDW-1:0] snp_id
);
    localparam int TAG_W = AW - IDX_W;

    logic             p_hit, s_hit, kill_req;
    logic [DW-1:0]    p_data;
    logic             bus_act, sel_bus, fill_en, upd_en;
    logic [IDX_W-1:0] c_idx, s_idx;
    logic [TAG_W-1:0] c_tag, s_tag;

    assign c_idx = cpu_addr[IDX_W-1:0];
    assign c_tag = cpu_addr[AW-1:IDX_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[AW-1:IDX_W];

    wti_req_seq u_seq (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .p_hit(p_hit),
        .bus_gnt(bus_gnt), .bus_done(bus_done),
        .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_act(bus_act),
        .sel_bus(sel_bus), .fill_en(fill_en), .upd_en(upd_en)
    );

    wti_snoop_filter #(.IDW(IDW), .AGENT_ID(AGENT_ID)) u_filt (
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_id(snp_id),
        .kill_req(kill_req)
    );

    wti_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_store (
        .clk(clk), .rst(rst),
        .p_idx(c_idx), .p_tag(c_tag), .p_hit(p_hit), .p_data(p_data),
        .s_idx(s_idx), .s_tag(s_tag), .s_kill_req(kill_req), .s_hit(s_hit),
        .fill_en(fill_en), .fill_idx(c_idx), .fill_tag(c_tag), .fill_data(bus_rdata),
        .upd_en(upd_en), .upd_idx(c_idx), .upd_data(cpu_wdata)
    );

    assign bus_we    = bus_act && cpu_write;
    assign bus_addr  = bus_act ? cpu_addr : '0;
    assign bus_wdata = (bus_act && cpu_write) ? cpu_wdata : '0;
    assign bus_src   = IDW'(AGENT_ID);
    assign cpu_rdata = sel_bus ? bus_rdata : p_data;

    // R10: a granted request is released on the next cycle
    p_gnt_release_r10: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_gnt |=> !bus_req)
        else $error("request held after grant");

    // R3: a pending request keeps its address and direction
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we))
        else $error("pending request changed");

    // R2: completion never coincides with an open bus request
    p_ready_no_req_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !bus_req)
        else $error("completion while requesting");

    // R5: a store completes only with the bus completion strobe
    p_store_done_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_valid && cpu_ready && cpu_write |-> bus_done)
        else $error("store completed without bus");

endmodule

// File: tb/wti_snoop_ctrl_test.sv
module wti_snoop_ctrl_test;
    localparam int AW = 8, DW = 16, IDX_W = 2, IDW = 2, ME = 1;
    localparam int NL = 1 << IDX_W;

    logic clk = 0, rst = 1;
    logic cpu_valid = 0, cpu_write = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic bus_req, bus_we;
    logic bus_gnt = 0, bus_done = 0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata = '0;
    logic [IDW-1:0] bus_src;
    logic snp_valid = 0, snp_write = 0;
    logic [AW-1:0] snp_addr = '0;
    logic [IDW-1:0] snp_id = '0;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    int g_delay = 0, d_delay = 0, rd_val = 0;

    wti_snoop_ctrl #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .IDW(IDW), .AGENT_ID(ME)) uut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_src(bus_src),
        .bus_rdata(bus_rdata), .bus_done(bus_done), .snp_valid(snp_valid),
        .snp_write(snp_write), .snp_addr(snp_addr), .snp_id(snp_id)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus agent: grants and completes after programmable delays
    int gcnt = 0, dcnt = 0;
    bit in_wait = 0;
    always @(negedge clk) begin
        bus_gnt = 0;
        bus_done = 0;
        bus_rdata = DW'(rd_val);
        if (bus_req) begin
            if (gcnt >= g_delay) begin bus_gnt = 1; gcnt = 0; in_wait = 1; dcnt = 0; end
            else gcnt++;
        end else if (in_wait) begin
            if (dcnt >= d_delay) begin bus_done = 1; in_wait = 0; end
            else dcnt++;
        end
    end

    // behavioural reference model, compared every cycle just before the rising edge
    bit m_v [NL];
    int m_tag [NL];
    int m_dat [NL];
    int m_ph = 0; // 0 idle, 1 waiting grant, 2 waiting completion
    always @(negedge clk) begin
        #8;
        if (rst) begin
            foreach (m_v[i]) begin m_v[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
            m_ph = 0;
        end else if (!finished) begin
            int idx, tg, si, stg, e_data;
            bit hit, e_ready, e_req;
            idx = int'(cpu_addr) % NL;
            tg  = int'(cpu_addr) / NL;
            hit = m_v[idx] && (m_tag[idx] == tg);
            e_ready = (m_ph == 0) ? (cpu_valid && !cpu_write && hit) : ((m_ph == 2) ? bus_done : 1'b0);
            e_req = (m_ph == 1);
            e_data = (m_ph == 2) ? int'(bus_rdata) : m_dat[idx];
            chk(cpu_ready === e_ready, "R2/R4/R5 cpu_ready", int'(cpu_ready), int'(e_ready));
            chk(bus_req === e_req, "R1/R3/R10 bus_req", int'(bus_req), int'(e_req));
            if (e_req) begin
                chk(bus_we === cpu_write, "R3/R5 bus_we", int'(bus_we), int'(cpu_write));
                chk(bus_addr === cpu_addr, "R3/R5 bus_addr", int'(bus_addr), int'(cpu_addr));
                if (cpu_write)
                    chk(bus_wdata === cpu_wdata, "R5 bus_wdata", int'(bus_wdata), int'(cpu_wdata));
            end
            if (e_ready && !cpu_write)
                chk(cpu_rdata === DW'(e_data), "R2/R4 cpu_rdata", int'(cpu_rdata), e_data);
            chk(bus_src === IDW'(ME), "R8 bus_src", int'(bus_src), ME);
            case (m_ph)
                0: if (cpu_valid && (cpu_write || !hit)) m_ph = 1;
                1: if (bus_gnt) begin
                       if (cpu_write && hit) m_dat[idx] = int'(cpu_wdata);
                       m_ph = 2;
                   end
                2: if (bus_done) begin
                       if (!cpu_write) begin m_v[idx] = 1; m_tag[idx] = tg; m_dat[idx] = int'(bus_rdata); end
                       m_ph = 0;
                   end
                default: m_ph = 0;
            endcase
            if (snp_valid && snp_write && int'(snp_id) != ME) begin
                si  = int'(snp_addr) % NL;
                stg = int'(snp_addr) / NL;
                if (m_v[si] && m_tag[si] == stg) m_v[si] = 0;
            end
        end
    end

    task automatic cpu_op(input bit we, input int a, input int wd, input int g, input int d,
                          input int rv, output int lat, output int rd);
        g_delay = g; d_delay = d; rd_val = rv;
        cpu_valid = 1; cpu_write = we; cpu_addr = AW'(a); cpu_wdata = DW'(wd);
        lat = 0; rd = 0;
        forever begin
            #8;
            lat++;
            if (cpu_ready) begin rd = int'(cpu_rdata); break; end
            @(negedge clk);
            snp_valid = 0;
        end
        @(negedge clk);
        cpu_valid = 0; cpu_write = 0; snp_valid = 0;
    endtask

    task automatic snoop(input bit we, input int a, input int id);
        snp_valid = 1; snp_write = we; snp_addr = AW'(a); snp_id = IDW'(id);
        @(negedge clk);
        snp_valid = 0; snp_write = 0;
    endtask

    localparam int A = 8'h05, B = 8'h09, C = 8'h02;

    initial begin
        int lat, rd;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: first load after reset misses
        cpu_op(0, A, 0, 1, 0, 16'h1234, lat, rd);
        chk(lat > 1, "R1 first load misses", lat, 3);
        chk(rd == 16'h1234, "R4 fill data", rd, 16'h1234);
        // R2 / R4: line now resident
        cpu_op(0, A, 0, 0, 0, 0, lat, rd);
        chk(lat == 1, "R2 hit latency", lat, 1);
        chk(rd == 16'h1234, "R2 hit data", rd, 16'h1234);
        // R5 / R6: store hit goes to bus and updates the local word
        cpu_op(1, A, 16'hBEEF, 2, 1, 0, lat, rd);
        chk(lat >= 3, "R5 store uses bus", lat, 3);
        cpu_op(0, A, 0, 0, 0, 0, lat, rd);
        chk(lat == 1 && rd == 16'hBEEF, "R6 store hit updated line", rd, 16'hBEEF);
        // R6: store miss does not allocate
        cpu_op(1, C, 16'h7777, 0, 0, 0, lat, rd);
        cpu_op(0, C, 0, 0, 0, 16'h0C0C, lat, rd);
        chk(lat > 1, "R6 store miss no allocate", lat, 3);
        chk(rd == 16'h0C0C, "R6 load after store miss", rd, 16'h0C0C);
        // R7: foreign write invalidates
        snoop(1, A, 2);
        cpu_op(0, A, 0, 0, 0, 16'hAAAA, lat, rd);
        chk(lat > 1, "R7 foreign write invalidates", lat, 3);
        chk(rd == 16'hAAAA, "R7 refetched data", rd, 16'hAAAA);
        // R8: own write and foreign read are ignored
        snoop(1, A, ME);
        snoop(0, A, 2);
        cpu_op(0, A, 0, 0, 0, 0, lat, rd);
        chk(lat == 1 && rd == 16'hAAAA, "R8 line survives", lat, 1);
        // R11: same index, different tag
        snoop(1, B, 3);
        cpu_op(0, A, 0, 0, 0, 0, lat, rd);
        chk(lat == 1, "R11 other tag kept line", lat, 1);
        // R9: snoop in the same cycle as a load hit to the same line
        snp_valid = 1; snp_write = 1; snp_addr = AW'(A); snp_id = 2'd2;
        cpu_op(0, A, 0, 0, 0, 0, lat, rd);
        chk(lat == 1, "R9 no stall", lat, 1);
        chk(rd == 16'hAAAA, "R9 old word returned", rd, 16'hAAAA);
        cpu_op(0, A, 0, 0, 0, 16'h5555, lat, rd);
        chk(lat > 1, "R9 line gone afterwards", lat, 3);
        // R10: long grant wait, then replacement at the same index
        cpu_op(0, B, 0, 4, 2, 16'h0B0B, lat, rd);
        chk(lat == 1 + 5 + 3, "R10 single outstanding request", lat, 9);
        chk(rd == 16'h0B0B, "R4 replacement fill", rd, 16'h0B0B);
        cpu_op(0, A, 0, 0, 0, 16'h5555, lat, rd);
        chk(lat > 1, "R4 replaced line misses", lat, 3);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule